// File: doc/BRIEF.md
# Fractional Sample Clock Generator

This block turns a reference tick stream into a sample-rate strobe whose rate is a rational fraction of that reference. Each generator keeps a phase accumulator. On every tick of its chosen reference it adds a programmed step. Each time the sum passes a programmed modulus, it subtracts the modulus and emits one strobe. The strobe rate is therefore the reference rate times step over modulus. The 44.1 kHz and 48 kHz sample-rate families, and a rate recovered from a digital audio receiver, can all be derived this way without a PLL.

Several independent generators sit behind one write port. Each generator has two registers. The source register picks which reference tick input drives it. The ratio register holds the step and the modulus. The modulus is stored minus one, so the full 16-bit field reaches a modulus of 65536. Writing the ratio register restarts the phase from zero, so a new ratio starts from a known point.

Top module: `frac_sample_clk`

## Requirements
- R1: After reset every strobe output is low, every generator has step 0 and source 0, and no strobe appears however the reference ticks toggle.
- R2: The ratio register holds the step in bits 15:0 and the modulus control in bits 31:16. The effective modulus is the modulus control plus one, so 0xFFFF gives 65536.
- R3: The source register's low two bits choose the reference. Code 0 follows `ref_tick_i[0]`, code 1 follows `ref_tick_i[1]` and code 2 follows `ref_tick_i[2]`. Ticks on the other inputs are ignored.
- R4: Source code 3 is reserved, and a generator set to it emits no strobes.
- R5: Starting from a ratio write, after N ticks of its reference a generator has emitted exactly floor(N × step / modulus) strobes.
- R6: A strobe is high for exactly one clock cycle: the cycle after the clock edge that sampled the reference tick that caused the wrap.
- R7: A step of 0 stops the generator; no strobe appears.
- R8: A step larger than the modulus is clamped to the modulus, which gives exactly one strobe per reference tick while the accumulator stays below the modulus.
- R9: A ratio write clears the accumulator. If a ratio write and a reference tick land on the same clock edge, the write wins and no strobe is emitted for that tick.
- R10: A write changes only the addressed generator. A write to an index with no generator (index 3) changes nothing.
- R11: A source register write keeps the accumulator phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | NUM_REF | One-cycle tick per reference: 0 = 48 kHz family, 1 = 44.1 kHz family, 2 = recovered |
| wr_en_i | input | 1 | Register write strobe |
| wr_gen_i | input | GEN_IDX_W | Generator index of the write |
| wr_reg_i | input | 1 | Register select: 0 = source, 1 = ratio |
| wr_data_i | input | 2*INC_W | Write data |
| strobe_o | output | NUM_GEN | One-cycle sample strobe per generator |

## Verification
The bench builds the block with its defaults: three generators, three references and 16-bit fields. With 16-bit fields the modulus control can be 0xFFFF, which reaches the 65536 modulus corner whose effective modulus needs a seventeenth bit. With three generators the 2-bit index has one value with no generator behind it, so the bench can check that a stray write to index 3 leaves every generator alone. Three references with a 2-bit select leave exactly one reserved code to exercise.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_FAM48 = 2'd0,
    SRC_FAM44 = 2'd1,
    SRC_RECOV = 2'd2,
    SRC_OFF   = 2'd3
  } fsc_src_e;

  typedef enum logic {
    REG_SRC   = 1'b0,
    REG_RATIO = 1'b1
  } fsc_reg_e;
endpackage

// File: rtl/fsc_cfg_reg.sv
module fsc_cfg_reg
  import fsc_pkg::*;
#(
  parameter int INC_W     = 16,
  parameter int GEN_IDX_W = 2,
  parameter int IDX       = 0,
  localparam int ACC_W    = INC_W + 1,
  localparam int WORD_W   = 2 * INC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [GEN_IDX_W-1:0] wr_gen_i,
  input  logic                 wr_reg_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  output fsc_src_e             src_o,
  output logic [INC_W-1:0]     inc_o,
  output logic [ACC_W-1:0]     modinc_o,
  output logic                 clr_o
);
  localparam logic [GEN_IDX_W-1:0] MY_IDX = GEN_IDX_W'(IDX);

  fsc_src_e          src_q;
  logic [WORD_W-1:0] ratio_q;
  logic              hit;

  assign hit = wr_en_i && (wr_gen_i == MY_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= SRC_FAM48;
      ratio_q <= '0;
    end else if (hit) begin
      if (fsc_reg_e'(wr_reg_i) == REG_RATIO) ratio_q <= wr_data_i;
      else                                   src_q   <= fsc_src_e'(wr_data_i[SEL_W-1:0]);
    end
  end

  assign src_o    = src_q;
  assign inc_o    = ratio_q[INC_W-1:0];
  assign modinc_o = ACC_W'(ratio_q[WORD_W-1:INC_W]) + ACC_W'(1);
  assign clr_o    = hit && (fsc_reg_e'(wr_reg_i) == REG_RATIO);

  // R10: writes aimed elsewhere leave this configuration untouched
  a_r10_cfg_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit) |=> ($stable(src_q) && $stable(ratio_q)));
endmodule

// File: rtl/fsc_src_mux.sv
module fsc_src_mux
  import fsc_pkg::*;
#(
  parameter int NUM_REF = 3
) (
  input  fsc_src_e           src_i,
  input  logic [NUM_REF-1:0] ref_tick_i,
  output logic               tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int r = 0; r < NUM_REF; r++) begin
      if (int'(src_i) == r) tick_o = ref_tick_i[r];
    end
  end
endmodule

// File: rtl/fsc_accum.sv
module fsc_accum #(
  parameter int INC_W  = 16,
  localparam int ACC_W = INC_W + 1,
  localparam int SUM_W = INC_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] modinc_i,
  output logic             strobe_o
);
  logic [ACC_W-1:0] acc_q, inc_eff;
  logic [SUM_W-1:0] sum, rem;
  logic             wrap, strobe_q;

  always_comb begin
    inc_eff = ({1'b0, inc_i} > modinc_i) ? modinc_i : {1'b0, inc_i};
    sum     = {1'b0, acc_q} + {1'b0, inc_eff};
    wrap    = sum >= {1'b0, modinc_i};
    rem     = wrap ? (sum - {1'b0, modinc_i}) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else if (clr_i) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else if (tick_i) begin
      acc_q    <= rem[ACC_W-1:0];
      strobe_q <= wrap;
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign strobe_o = strobe_q;

  a_r8_acc_below_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < modinc_i);
  a_r7_zero_step_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == '0) |=> !strobe_q);
  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0 && !strobe_q));
  a_r6_strobe_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> $past(tick_i));
endmodule

// File: rtl/frac_sample_clk.sv
module frac_sample_clk
  import fsc_pkg::*;
#(
  parameter int  NUM_GEN   = 3,
  parameter int  NUM_REF   = 3,
  parameter int  INC_W     = 16,
  localparam int GEN_IDX_W = (NUM_GEN > 1) ? $clog2(NUM_GEN + 1) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_REF-1:0]   ref_tick_i,
  input  logic                 wr_en_i,
  input  logic [GEN_IDX_W-1:0] wr_gen_i,
  input  logic                 wr_reg_i,
  input  logic [2*INC_W-1:0]   wr_data_i,
  output logic [NUM_GEN-1:0]   strobe_o
);
  localparam int ACC_W = INC_W + 1;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    fsc_src_e         src;
    logic [INC_W-1:0] inc;
    logic [ACC_W-1:0] modinc;
    logic             clr, tick;

    fsc_cfg_reg #(.INC_W(INC_W), .GEN_IDX_W(GEN_IDX_W), .IDX(g)) u_cfg (
      .clk_i, .rst_ni, .wr_en_i, .wr_gen_i, .wr_reg_i, .wr_data_i,
      .src_o(src), .inc_o(inc), .modinc_o(modinc), .clr_o(clr)
    );

    fsc_src_mux #(.NUM_REF(NUM_REF)) u_mux (
      .src_i(src), .ref_tick_i, .tick_o(tick)
    );

    fsc_accum #(.INC_W(INC_W)) u_acc (
      .clk_i, .rst_ni, .tick_i(tick), .clr_i(clr),
      .inc_i(inc), .modinc_i(modinc), .strobe_o(strobe_o[g])
    );

    a_r4_reserved_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src == SRC_OFF) |=> !strobe_o[g]);
  end
endmodule

// File: tb/frac_sample_clk_bench.sv
module frac_sample_clk_bench;
  localparam int NG = 3, NR = 3, IW = 16, GW = 2;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic [NR-1:0] ref_tick = '0;
  logic          wr_en = 1'b0, wr_reg = 1'b0;
  logic [GW-1:0] wr_gen = '0;
  logic [31:0]   wr_data = '0;
  logic [NG-1:0] strobe;

  int checks = 0, fails = 0;
  int cnt [NG];

  always #2 clk = ~clk;

  frac_sample_clk u_frac_sample_clk (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick),
    .wr_en_i(wr_en), .wr_gen_i(wr_gen), .wr_reg_i(wr_reg),
    .wr_data_i(wr_data), .strobe_o(strobe)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ratio(input int inc, input int modinc);
    ratio = {16'(modinc - 1), 16'(inc)};
  endfunction

  task automatic wr(input int g, input bit r, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_gen = GW'(g); wr_reg = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_cnt();
    for (int g = 0; g < NG; g++) cnt[g] = 0;
  endtask

  // one tick; R6: strobe from an earlier tick must be gone
  task automatic tick(input logic [NR-1:0] m);
    @(negedge clk);
    chk(strobe == '0, "R6 width", strobe, 0);
    ref_tick = m;
    @(negedge clk);
    ref_tick = '0;
    for (int g = 0; g < NG; g++) cnt[g] += int'(strobe[g]);
  endtask

  task automatic run(input logic [NR-1:0] m, input int n);
    for (int i = 0; i < n; i++) tick(m);
  endtask

  task automatic t_reset();
    chk(strobe == '0, "R1 strobe after reset", strobe, 0);
    clr_cnt();
    run(3'b111, 6);
    for (int g = 0; g < NG; g++) chk(cnt[g] == 0, "R1 idle after reset", cnt[g], 0);
  endtask

  task automatic t_ratio_count();
    int inc_l [4] = '{3, 147, 32768, 5};
    int mod_l [4] = '{7, 160, 65536, 5};
    int n_l   [4] = '{50, 320, 12, 9};
    wr(0, 0, 32'd0);
    for (int k = 0; k < 4; k++) begin
      longint exp;
      wr(0, 1, ratio(inc_l[k], mod_l[k]));
      clr_cnt();
      run(3'b001, n_l[k]);
      exp = (longint'(n_l[k]) * inc_l[k]) / mod_l[k];
      chk(cnt[0] == exp, (mod_l[k] == 65536) ? "R2 full modulus" : "R5 count", cnt[0], exp);
    end
  endtask

  task automatic t_source();
    wr(1, 1, ratio(1, 1));
    for (int s = 0; s < 3; s++) begin
      wr(1, 0, 32'(s));
      for (int k = 0; k < 3; k++) begin
        clr_cnt();
        run(NR'(1 << k), 4);
        chk(cnt[1] == ((k == s) ? 4 : 0), "R3 source routing", cnt[1], (k == s) ? 4 : 0);
      end
    end
  endtask

  task automatic t_reserved();
    wr(1, 0, 32'd3);
    clr_cnt();
    run(3'b111, 6);
    chk(cnt[1] == 0, "R4 reserved source", cnt[1], 0);
  endtask

  task automatic t_zero_step();
    wr(2, 0, 32'd0);
    wr(2, 1, ratio(0, 3));
    clr_cnt();
    run(3'b001, 6);
    chk(cnt[2] == 0, "R7 zero step", cnt[2], 0);
  endtask

  task automatic t_clamp();
    wr(2, 1, ratio(10, 4));
    clr_cnt();
    run(3'b001, 8);
    chk(cnt[2] == 8, "R8 clamp", cnt[2], 8);
    wr(2, 1, ratio(300, 100));
    clr_cnt();
    run(3'b001, 5);
    chk(cnt[2] == 5, "R8 clamp", cnt[2], 5);
  endtask

  task automatic t_clear();
    wr(2, 1, ratio(1, 4));
    clr_cnt(); run(3'b001, 3);
    chk(cnt[2] == 0, "R9 pre", cnt[2], 0);
    wr(2, 1, ratio(1, 4));
    clr_cnt(); run(3'b001, 3);
    chk(cnt[2] == 0, "R9 cleared", cnt[2], 0);
    run(3'b001, 1);
    chk(cnt[2] == 1, "R9 restart", cnt[2], 1);
    wr(2, 1, ratio(1, 2));
    clr_cnt(); run(3'b001, 1);
    chk(cnt[2] == 0, "R9 half phase", cnt[2], 0);
    @(negedge clk);
    wr_en = 1'b1; wr_gen = 2'd2; wr_reg = 1'b1; wr_data = ratio(1, 2); ref_tick = 3'b001;
    @(negedge clk);
    wr_en = 1'b0; ref_tick = '0;
    chk(strobe[2] == 1'b0, "R9 write beats tick", strobe[2], 0);
    clr_cnt(); run(3'b001, 1);
    chk(cnt[2] == 0, "R9 after collision", cnt[2], 0);
    run(3'b001, 1);
    chk(cnt[2] == 1, "R9 after collision", cnt[2], 1);
  endtask

  task automatic t_indep();
    wr(0, 0, 32'd0);
    wr(0, 1, ratio(1, 4));
    wr(2, 1, ratio(0, 4));
    clr_cnt(); run(3'b001, 2);
    wr(3, 1, ratio(1, 1));
    wr(3, 0, 32'd1);
    run(3'b001, 2);
    chk(cnt[0] == 1, "R10 stray index", cnt[0], 1);
    chk(cnt[1] == 0, "R10 other gen", cnt[1], 0);
    chk(cnt[2] == 0, "R10 other gen", cnt[2], 0);
    wr(0, 1, ratio(1, 4));
    clr_cnt(); run(3'b001, 2);
    wr(2, 1, ratio(1, 1));
    run(3'b001, 2);
    chk(cnt[0] == 1, "R10 neighbour write", cnt[0], 1);
    chk(cnt[2] == 2, "R10 neighbour write", cnt[2], 2);
  endtask

  task automatic t_src_keep();
    wr(0, 0, 32'd0);
    wr(0, 1, ratio(1, 4));
    clr_cnt(); run(3'b001, 2);
    wr(0, 0, 32'd1);
    run(3'b010, 2);
    chk(cnt[0] == 1, "R11 phase kept", cnt[0], 1);
  endtask

  task automatic t_timing();
    wr(0, 0, 32'd0);
    wr(0, 1, ratio(1, 1));
    @(negedge clk);
    ref_tick = 3'b001;
    @(negedge clk);
    ref_tick = '0;
    chk(strobe[0] == 1'b1, "R6 strobe next cycle", strobe[0], 1);
    @(negedge clk);
    chk(strobe[0] == 1'b0, "R6 one cycle", strobe[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_ratio_count();
    t_source();
    t_reserved();
    t_zero_step();
    t_clamp();
    t_clear();
    t_indep();
    t_src_keep();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule